// File: doc/BRIEF.md
# CPU and PCI Clock Divider with Stop Gating

This block derives a pair of CPU clock copies and a group of bus clocks from a single master clock that runs at twice the CPU rate. The CPU outputs toggle on every master edge. The bus clocks are divided down from the same count, so they always stay synchronous to the CPU clocks. A frequency select sets the CPU-to-bus ratio. With the select low the bus clock is the CPU clock divided by 2. With the select high it is the CPU clock divided by 3. In both cases the bus clock keeps the same nominal rate while the CPU rate changes.

Three active-low controls gate the outputs:
- A CPU hold parks both CPU copies low.
- A bus hold parks the five gated bus clocks low. One free-running bus clock ignores this hold.
- A sleep input parks every output low, including the free-running bus clock.

Each control passes through a two-stage synchronizer. Every gate opens and closes only while its clock is in the low phase. As a result, an output never shows a shortened high pulse. It stops after a complete cycle and restarts with a complete cycle. All outputs come straight from flip-flops.

Top module: `cpu_pci_clkgen`

## Requirements
- R1: While `rst_n` is low, every output is 0. In the first cycle after release, every output is still 0.
- R2: When the CPU clock is running, `cpu_clk` alternates on every master cycle: one cycle high, then one cycle low. All copies are equal at every cycle.
- R3: With `sel_fast` = 0, `pci_clk_free` is high for 2 master cycles and low for 2. With `sel_fast` = 1, it is high for 3 and low for 3.
- R4: Whenever both clocks are running, each rising edge of `pci_clk_free` or `pci_clk` lands in the same master cycle as a rising edge of `cpu_clk`.
- R5: A change of `sel_fast` takes effect only at the end of a bus clock period. Every bus pulse around the change is a full pulse of either the old ratio or the new one (width 2 or 3).
- R6: After `cpu_hold_n` falls, `cpu_clk` is low from the sixth master cycle onward and stays low. Every pulse before that point is full width.
- R7: After `cpu_hold_n` rises, `cpu_clk` resumes alternating within six master cycles, and its first pulse is full width.
- R8: `pci_hold_n` is taken at the rising edge of the free-running bus clock and is applied from the next bus period. Within 2·period+3 master cycles, `pci_clk` is 0 and stays 0 while the hold is low.
- R9: `pci_hold_n` has no effect on `pci_clk_free`, which keeps producing full pulses at the selected ratio. A gated bus output is high only while the free-running bus clock is high.
- R10: Every high pulse on `pci_clk` is full width, including the pulses around a bus hold and its release. All gated copies are equal at every cycle.
- R11: After `sleep_n` falls, every output, including `pci_clk_free`, is 0 within 2·period+3 master cycles and stays 0.
- R12: After `sleep_n` rises, the CPU and bus clocks restart at full rate, each beginning with a full-width pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Master clock at twice the CPU clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_fast | input | 1 | Ratio select: 0 = bus is CPU/2, 1 = bus is CPU/3 |
| cpu_hold_n | input | 1 | Parks the CPU clocks low when 0 |
| pci_hold_n | input | 1 | Parks the gated bus clocks low when 0 |
| sleep_n | input | 1 | Parks all outputs low when 0 |
| cpu_clk | output | NCPU | CPU clock copies |
| pci_clk_free | output | 1 | Free-running bus clock, unaffected by the bus hold |
| pci_clk | output | NPCI | Gated bus clock copies |

## Verification
The most likely internal faults are these:
- a phase counter that wraps at the wrong count;
- a gate register that updates outside the low phase;
- a ratio register that loads mid-period.

Each of them shows up at the ports within one bus period. It appears as a high pulse of the wrong width, a CPU edge that misses a bus rising edge, or a gated copy that stays high past its hold window. A synchronizer with the wrong depth moves the stop point outside the stated latency window. The bench catches this a few master cycles after the control input changes.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

   // Bus-to-CPU ratio selected by the frequency select input
   typedef enum logic {
      RATIO_SLOW = 1'b0,   // bus = CPU / DIV_LO
      RATIO_FAST = 1'b1    // bus = CPU / DIV_HI
   } ratio_e;

   // Index of each control bit inside the synchronizer bundle
   localparam int unsigned CTL_SEL   = 0;
   localparam int unsigned CTL_CPU   = 1;
   localparam int unsigned CTL_BUS   = 2;
   localparam int unsigned CTL_WAKE  = 3;
   localparam int unsigned CTL_WIDTH = 4;

endpackage

// File: rtl/cpg_sync.sv
module cpg_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("cpg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cpg_sync: W must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic [W-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stg[s-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/cpg_phase.sv
module cpg_phase #(
   parameter int unsigned DIV_LO = 2,
   parameter int unsigned DIV_HI = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_s,
   output logic cpu_ph,
   output logic pci_ph,
   output logic cpu_upd,
   output logic pci_start,
   output logic pci_end
);
   import cpg_pkg::*;

   localparam int unsigned PER_LO  = 2 * DIV_LO;
   localparam int unsigned PER_HI  = 2 * DIV_HI;
   localparam int unsigned PER_MAX = (PER_HI > PER_LO) ? PER_HI : PER_LO;
   localparam int unsigned CW      = $clog2(PER_MAX);

   typedef logic [CW-1:0] cnt_t;

   localparam cnt_t LAST_LO = cnt_t'(PER_LO - 1);
   localparam cnt_t LAST_HI = cnt_t'(PER_HI - 1);
   localparam cnt_t HALF_LO = cnt_t'(DIV_LO);
   localparam cnt_t HALF_HI = cnt_t'(DIV_HI);

   if (DIV_LO < 2) begin : g_bad_lo
      $error("cpg_phase: DIV_LO must be at least 2");
   end
   if (DIV_HI < DIV_LO) begin : g_bad_hi
      $error("cpg_phase: DIV_HI must not be below DIV_LO");
   end

   cnt_t   cnt;
   ratio_e ratio_q;
   cnt_t   last_v;
   cnt_t   half_v;

   always_comb begin
      last_v = (ratio_q == RATIO_FAST) ? LAST_HI : LAST_LO;
      half_v = (ratio_q == RATIO_FAST) ? HALF_HI : HALF_LO;
   end

   // Periods are even, so the CPU phase wraps without a seam
   assign pci_end   = (cnt == last_v);
   assign pci_start = (cnt == '0);
   assign cpu_ph    = ~cnt[0];
   assign cpu_upd   = cnt[0];
   assign pci_ph    = (cnt < half_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ratio_q <= RATIO_SLOW;
      end else if (pci_end) begin
         cnt     <= '0;
         ratio_q <= ratio_e'(fast_s);
      end else begin
         cnt     <= cnt + 1'b1;
      end
   end

   // R5
   ratio_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_q) |-> $past(pci_end));

endmodule

// File: rtl/cpg_gate.sv
module cpg_gate #(
   parameter int unsigned NCPU = 2,
   parameter int unsigned NPCI = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_run_s,
   input  logic            pci_run_s,
   input  logic            wake_s,
   input  logic            cpu_ph,
   input  logic            pci_ph,
   input  logic            cpu_upd,
   input  logic            pci_start,
   input  logic            pci_end,
   output logic [NCPU-1:0] cpu_q,
   output logic            free_q,
   output logic [NPCI-1:0] pci_q
);

   if (NCPU < 1) begin : g_bad_ncpu
      $error("cpg_gate: NCPU must be at least 1");
   end
   if (NPCI < 1) begin : g_bad_npci
      $error("cpg_gate: NPCI must be at least 1");
   end

   logic cpu_en;
   logic free_en;
   logic pci_smp;
   logic pci_en;

   // CPU gate moves only in the CPU low phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cpu_en <= 1'b0;
      else if (cpu_upd) cpu_en <= cpu_run_s & wake_s;
   end

   // Bus hold taken at the free bus clock rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pci_smp <= 1'b0;
      else if (pci_start) pci_smp <= pci_run_s;
   end

   // Bus gates move only at the last low cycle of a period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_en <= 1'b0;
         pci_en  <= 1'b0;
      end else if (pci_end) begin
         free_en <= wake_s;
         pci_en  <= wake_s & pci_smp;
      end
   end

   for (genvar i = 0; i < NCPU; i++) begin : g_cpu
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b0;
         else        r <= cpu_ph & cpu_en;
      end
      assign cpu_q[i] = r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_q <= 1'b0;
      else        free_q <= pci_ph & free_en;
   end

   for (genvar j = 0; j < NPCI; j++) begin : g_pci
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b0;
         else        r <= pci_ph & pci_en;
      end
      assign pci_q[j] = r;
   end

   // R6
   cpu_gate_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpu_en) |-> $past(cpu_upd));

   // R10
   pci_gate_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pci_en) |-> $past(pci_end));

   // R11
   free_gate_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(free_en) |-> $past(pci_end));

   // R2
   cpu_half_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_q[0] |=> !cpu_q[0]);

   // R9
   gated_under_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pci_q[0] |-> free_q);

   // R4
   edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(free_q) && cpu_en |-> cpu_q[0]);

endmodule

// File: rtl/cpu_pci_clkgen.sv
module cpu_pci_clkgen #(
   parameter int unsigned NCPU        = 2,
   parameter int unsigned NPCI        = 5,
   parameter int unsigned DIV_LO      = 2,
   parameter int unsigned DIV_HI      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk_2x,
   input  logic            rst_n,
   input  logic            sel_fast,
   input  logic            cpu_hold_n,
   input  logic            pci_hold_n,
   input  logic            sleep_n,
   output logic [NCPU-1:0] cpu_clk,
   output logic            pci_clk_free,
   output logic [NPCI-1:0] pci_clk
);
   import cpg_pkg::*;

   logic [CTL_WIDTH-1:0] ctl_raw;
   logic [CTL_WIDTH-1:0] ctl_s;
   logic cpu_ph, pci_ph, cpu_upd, pci_start, pci_end;

   always_comb begin
      ctl_raw           = '0;
      ctl_raw[CTL_SEL]  = sel_fast;
      ctl_raw[CTL_CPU]  = cpu_hold_n;
      ctl_raw[CTL_BUS]  = pci_hold_n;
      ctl_raw[CTL_WAKE] = sleep_n;
   end

   cpg_sync #(
      .W      (CTL_WIDTH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk_2x),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   cpg_phase #(
      .DIV_LO (DIV_LO),
      .DIV_HI (DIV_HI)
   ) u_phase (
      .clk       (clk_2x),
      .rst_n     (rst_n),
      .fast_s    (ctl_s[CTL_SEL]),
      .cpu_ph    (cpu_ph),
      .pci_ph    (pci_ph),
      .cpu_upd   (cpu_upd),
      .pci_start (pci_start),
      .pci_end   (pci_end)
   );

   cpg_gate #(
      .NCPU (NCPU),
      .NPCI (NPCI)
   ) u_gate (
      .clk       (clk_2x),
      .rst_n     (rst_n),
      .cpu_run_s (ctl_s[CTL_CPU]),
      .pci_run_s (ctl_s[CTL_BUS]),
      .wake_s    (ctl_s[CTL_WAKE]),
      .cpu_ph    (cpu_ph),
      .pci_ph    (pci_ph),
      .cpu_upd   (cpu_upd),
      .pci_start (pci_start),
      .pci_end   (pci_end),
      .cpu_q     (cpu_clk),
      .free_q    (pci_clk_free),
      .pci_q     (pci_clk)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk_2x)
      !$past(rst_n) && rst_n |-> (cpu_clk == '0) && !pci_clk_free && (pci_clk == '0));

endmodule

// File: tb/cpu_pci_clkgen_test.sv
module cpu_pci_clkgen_test;
   localparam int NCPU = 2;
   localparam int NPCI = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_fast = 1'b0;
   logic cpu_hold_n = 1'b1;
   logic pci_hold_n = 1'b1;
   logic sleep_n = 1'b1;
   logic [NCPU-1:0] cpu_clk;
   logic pci_clk_free;
   logic [NPCI-1:0] pci_clk;

   always #10 clk = ~clk;

   cpu_pci_clkgen #(.NCPU(NCPU), .NPCI(NPCI)) uut (
      .clk_2x(clk), .rst_n(rst_n), .sel_fast(sel_fast),
      .cpu_hold_n(cpu_hold_n), .pci_hold_n(pci_hold_n), .sleep_n(sleep_n),
      .cpu_clk(cpu_clk), .pci_clk_free(pci_clk_free), .pci_clk(pci_clk));

   int nchk = 0;
   int nerr = 0;
   int exp_q[$];
   int ratio = 2;
   bit settle = 1'b1;
   bit cpu_live = 1'b0;
   bit free_steady = 1'b0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive_slot();
      @(posedge clk);
      #5;
   endtask

   task automatic push_free(input int n);
      for (int k = 0; k < n; k++) exp_q.push_back(ratio);
   endtask

   task automatic wait_empty(input string tag);
      int n = 0;
      while (exp_q.size() > 0 && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic cpu_alt(input string tag, input int n);
      logic p;
      @(negedge clk);
      p = cpu_clk[0];
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(cpu_clk[0] != p, tag, int'(cpu_clk[0]), int'(!p));
         p = cpu_clk[0];
      end
   endtask

   task automatic all_low(input string tag, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(cpu_clk == '0 && !pci_clk_free && pci_clk == '0, tag,
             int'({cpu_clk, pci_clk_free, pci_clk}), 0);
      end
   endtask

   // Monitor: measures pulses and pops the scoreboard
   logic pf = 1'b0;
   logic pg = 1'b0;
   int hf = 0;
   int lf = 0;
   int hg = 0;
   int grises = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cpu_clk == {NCPU{cpu_clk[0]}}, "R2 cpu copies equal", int'(cpu_clk), 0);
         chk(pci_clk == {NPCI{pci_clk[0]}}, "R10 gated copies equal", int'(pci_clk), 0);
         if (pci_clk_free && !pf) begin
            if (free_steady && !settle) chk(lf == ratio, "R3 free low width", lf, ratio);
            if (cpu_live) chk(cpu_clk[0], "R4 cpu rise at free bus rise", int'(cpu_clk[0]), 1);
            lf = 0;
         end
         if (!pci_clk_free && pf) begin
            int e;
            chk(hf == 2 || hf == 3, "R5 free pulse full width", hf, ratio);
            if (!settle) chk(hf == ratio, "R9 free high width", hf, ratio);
            if (exp_q.size() > 0) begin
               e = exp_q.pop_front();
               chk(hf == e, "R3 scoreboard free pulse", hf, e);
            end
            hf = 0;
         end
         if (pci_clk[0] && !pg) begin
            grises++;
            if (cpu_live) chk(cpu_clk[0], "R4 cpu rise at gated bus rise", int'(cpu_clk[0]), 1);
         end
         if (!pci_clk[0] && pg) begin
            chk(hg == 2 || hg == 3, "R10 gated pulse full width", hg, ratio);
            if (!settle) chk(hg == ratio, "R10 gated high width", hg, ratio);
            hg = 0;
         end
         if (pci_clk_free) hf++; else lf++;
         if (pci_clk[0]) hg++;
         pf = pci_clk_free;
         pg = pci_clk[0];
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int g0;
      repeat (3) @(negedge clk);
      chk(cpu_clk == '0 && !pci_clk_free && pci_clk == '0, "R1 outputs low in reset",
          int'({cpu_clk, pci_clk_free, pci_clk}), 0);
      drive_slot();
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_clk == '0 && !pci_clk_free && pci_clk == '0, "R1 outputs low after release",
          int'({cpu_clk, pci_clk_free, pci_clk}), 0);
      repeat (30) @(negedge clk);
      settle = 1'b0;
      free_steady = 1'b1;
      cpu_live = 1'b1;

      // CPU rate and bus ratio with select low
      cpu_alt("R2 cpu alternates div2", 8);
      push_free(3);
      wait_empty("R3 div2 pulses");

      // R5: switch to the fast ratio
      drive_slot();
      settle = 1'b1;
      sel_fast = 1'b1;
      ratio = 3;
      repeat (30) @(negedge clk);
      settle = 1'b0;
      push_free(3);
      wait_empty("R3 div3 pulses");
      cpu_alt("R2 cpu alternates div3", 8);

      // R6: CPU hold
      push_free(2);
      drive_slot();
      cpu_live = 1'b0;
      cpu_hold_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         chk(cpu_clk == '0, "R6 cpu parked low", int'(cpu_clk), 0);
      end
      wait_empty("R9 free bus runs during cpu hold");

      // R7: CPU release
      drive_slot();
      cpu_hold_n = 1'b1;
      repeat (6) @(negedge clk);
      cpu_alt("R7 cpu resumes", 8);
      cpu_live = 1'b1;

      // R8 and R9: bus hold
      drive_slot();
      pci_hold_n = 1'b0;
      push_free(4);
      repeat (18) @(negedge clk);
      for (int k = 0; k < 14; k++) begin
         @(negedge clk);
         chk(pci_clk == '0, "R8 gated bus parked low", int'(pci_clk), 0);
      end
      wait_empty("R9 free bus ignores bus hold");

      // R10: release of the bus hold
      drive_slot();
      pci_hold_n = 1'b1;
      g0 = grises;
      repeat (30) @(negedge clk);
      chk(grises - g0 >= 2, "R10 gated bus resumes", grises - g0, 2);

      // R5: switch back while gated clocks run
      drive_slot();
      settle = 1'b1;
      sel_fast = 1'b0;
      ratio = 2;
      repeat (30) @(negedge clk);
      settle = 1'b0;
      push_free(2);
      wait_empty("R5 pulses after switch back");

      // R11: sleep
      drive_slot();
      cpu_live = 1'b0;
      free_steady = 1'b0;
      sleep_n = 1'b0;
      repeat (18) @(negedge clk);
      all_low("R11 all outputs parked", 20);

      // R12: wake
      drive_slot();
      sleep_n = 1'b1;
      push_free(3);
      g0 = grises;
      repeat (6) @(negedge clk);
      cpu_alt("R12 cpu restarts", 8);
      wait_empty("R12 free bus restarts");
      chk(grises - g0 >= 1, "R12 gated bus restarts", grises - g0, 1);
      cpu_live = 1'b1;
      free_steady = 1'b1;
      repeat (20) @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule